// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address stream for synchronous burst reads from a memory array of 2,097,152 sixteen-bit words, so its addresses are 21 bits wide. The host samples a burst clock. Whichever transition of that clock has been picked as the active one drives every step of the sequencer. When chip enable and address-valid are both asserted (both active low) on an active transition, the sequencer captures a start address and a burst mode.

After the capture, a ready output stays low for a programmable number of active transitions. When it rises, the output address still holds the start word. Each later active transition then moves the address on. The move either wraps inside an aligned block of 8, 16 or 32 words, or increments without bound. Deasserting chip enable stops the burst at once.

The block runs in a single system clock domain. The burst clock is a slower, synchronous input, and the block detects its transitions internally.

Top module: `burst_addr_seq`

## Requirements
- R1: On an active burst-clock transition with ce_n=0 and avd_n=0, the start address and mode are captured. From the next system clock on, addr_out equals the start address, busy=1 and rdy=0.
- R2: With lat_cfg value L, rdy rises on the L-th active transition after the capturing one. Values 0 and 1 are treated as 2. addr_out keeps the start address until rdy is high.
- R3: In mode 2'b00 (continuous), each active transition with rdy=1 increments addr_out by one. 0x1FFFFF is followed by 0x000000.
- R4: Modes 2'b01, 2'b10 and 2'b11 select wrap lengths of 8, 16 and 32 words. Each active transition with rdy=1 increments the low 3, 4 or 5 address bits modulo the length, and the bits above them stay unchanged.
- R5: With edge_sel=0 a rising burst_clk transition is active. With edge_sel=1 a falling one is. A transition in the other direction changes nothing.
- R6: While ce_n=1, the next system clock leaves rdy=0 and busy=0, and addr_out holds its value.
- R7: Synchronous active-high reset gives addr_out=0, rdy=0 and busy=0.
- R8: avd_n=0 with ce_n=0 on an active transition during a burst restarts the burst from the newly given address, with rdy low again.
- R9: addr_out changes only on the system clock that follows an active transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_clk | input | 1 | Burst clock, synchronous to clk and slower |
| edge_sel | input | 1 | 0: rising transition active, 1: falling transition active |
| ce_n | input | 1 | Chip enable, active low |
| avd_n | input | 1 | Address valid, active low |
| addr_in | input | 21 | Start word address |
| mode_in | input | 2 | Burst mode: 00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| lat_cfg | input | 3 | Initial latency in active transitions (2 to 7) |
| addr_out | output | 21 | Current burst word address |
| rdy | output | 1 | Burst data valid |
| busy | output | 1 | Burst in progress |

## Verification
The checker watches four rules on every clock:
- Chip enable high clears rdy and busy.
- The address never moves without an active transition.
- rdy rises only while the start address is held.
- Each step follows its mode: the continuous step adds exactly one, and a wrapping step leaves the bits above bit 4 alone.

Some behaviours show only in the bench scenarios, which walk whole bursts:
- the exact latency count and the clamp of small values;
- the wrap point for each length and the array-top rollover;
- that transitions in the unselected direction are ignored;
- restart through address-valid.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int ADDR_W  = 21;
    localparam int LAT_W   = 3;
    localparam int LAT_MIN = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        BM_CONT = 2'b00,
        BM_W8   = 2'b01,
        BM_W16  = 2'b10,
        BM_W32  = 2'b11
    } burst_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        burst_mode_e       mode;
    } burst_ctx_t;

    function automatic logic [ADDR_W-1:0] wrap_mask(input burst_mode_e m);
        case (m)
            BM_W8:   return ADDR_W'(7);
            BM_W16:  return ADDR_W'(15);
            BM_W32:  return ADDR_W'(31);
            default: return '1;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input burst_mode_e m);
        logic [ADDR_W-1:0] msk;
        logic [ADDR_W-1:0] inc;
        msk = wrap_mask(m);
        inc = a + 1'b1;
        return (a & ~msk) | (inc & msk);
    endfunction

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] l);
        return (l < LAT_W'(LAT_MIN)) ? LAT_W'(LAT_MIN) : l;
    endfunction
endpackage

// File: rtl/burst_seq_edge.sv
module burst_seq_edge (
    input  logic clk,
    input  logic rst,
    input  logic burst_clk,
    input  logic edge_sel,
    output logic act_edge
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= burst_clk;
    end

    always_comb begin
        if (rst)
            act_edge = 1'b0;
        else if (edge_sel)
            act_edge = prev_q & ~burst_clk;
        else
            act_edge = ~prev_q & burst_clk;
    end
endmodule

// File: rtl/burst_seq_lat.sv
module burst_seq_lat
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] lat_cfg,
    input  logic             dec,
    output logic             last
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= clamp_lat(lat_cfg);
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == LAT_W'(1));
endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  burst_ctx_t        load_ctx,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output burst_mode_e       mode
);
    burst_ctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.addr <= '0;
            ctx_q.mode <= BM_CONT;
        end else if (load) begin
            ctx_q <= load_ctx;
        end else if (step) begin
            ctx_q.addr <= step_addr(ctx_q.addr, ctx_q.mode);
        end
    end

    assign addr = ctx_q.addr;
    assign mode = ctx_q.mode;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_clk,
    input  logic              edge_sel,
    input  logic              ce_n,
    input  logic              avd_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [1:0]        mode_in,
    input  logic [LAT_W-1:0]  lat_cfg,
    output logic [ADDR_W-1:0] addr_out,
    output logic              rdy,
    output logic              busy
);
    seq_state_e  state_q;
    logic        act_edge;
    logic        do_load;
    logic        do_dec;
    logic        do_step;
    logic        lat_last;
    burst_mode_e cur_mode;
    burst_ctx_t  new_ctx;

    burst_seq_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .burst_clk(burst_clk),
        .edge_sel (edge_sel),
        .act_edge (act_edge)
    );

    assign do_load = act_edge & ~ce_n & ~avd_n;
    assign do_dec  = act_edge & ~ce_n & avd_n & (state_q == ST_WAIT);
    assign do_step = act_edge & ~ce_n & avd_n & (state_q == ST_BURST);

    assign new_ctx.addr = addr_in;
    assign new_ctx.mode = burst_mode_e'(mode_in);

    burst_seq_lat u_lat (
        .clk    (clk),
        .rst    (rst),
        .load   (do_load),
        .lat_cfg(lat_cfg),
        .dec    (do_dec),
        .last   (lat_last)
    );

    burst_seq_addr u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (do_load),
        .load_ctx(new_ctx),
        .step    (do_step),
        .addr    (addr_out),
        .mode    (cur_mode)
    );

    always_ff @(posedge clk) begin
        if (rst || ce_n) begin
            state_q <= ST_IDLE;
        end else if (do_load) begin
            state_q <= ST_WAIT;
        end else if (do_dec && lat_last) begin
            state_q <= ST_BURST;
        end
    end

    assign rdy  = (state_q == ST_BURST);
    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              avd_n,
    input logic              act_edge,
    input logic [1:0]        cur_mode,
    input logic [ADDR_W-1:0] addr_out,
    input logic              rdy,
    input logic              busy
);
    // R6
    ce_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (!rdy && !busy));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !act_edge |=> $stable(addr_out));

    // R2
    rdy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $stable(addr_out));

    // R3
    cont_step_chk: assert property (@(posedge clk) disable iff (rst)
        (act_edge && rdy && !ce_n && avd_n && cur_mode == 2'b00)
        |=> addr_out == ADDR_W'($past(addr_out) + 1'b1));

    // R4
    wrap_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (act_edge && rdy && !ce_n && avd_n && cur_mode != 2'b00)
        |=> addr_out[ADDR_W-1:5] == $past(addr_out[ADDR_W-1:5]));
endmodule

bind burst_addr_seq burst_addr_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .avd_n   (avd_n),
    .act_edge(act_edge),
    .cur_mode(cur_mode),
    .addr_out(addr_out),
    .rdy     (rdy),
    .busy    (busy)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        burst_clk = 1'b0;
    logic        edge_sel = 1'b0;
    logic        ce_n = 1'b1;
    logic        avd_n = 1'b1;
    logic [20:0] addr_in = '0;
    logic [1:0]  mode_in = 2'b00;
    logic [2:0]  lat_cfg = 3'd2;
    logic [20:0] addr_out;
    logic        rdy;
    logic        busy;

    int n_checks = 0;
    int n_errs = 0;

    burst_addr_seq u_burst_addr_seq (
        .clk(clk), .rst(rst), .burst_clk(burst_clk), .edge_sel(edge_sel),
        .ce_n(ce_n), .avd_n(avd_n), .addr_in(addr_in), .mode_in(mode_in),
        .lat_cfg(lat_cfg), .addr_out(addr_out), .rdy(rdy), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [20:0] act, input logic [20:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=0x%06h expected=0x%06h", tag, act, exp);
        end
    endtask

    // One active transition; outputs are sampled one negedge after it is seen.
    task automatic act_edge();
        @(negedge clk) burst_clk = edge_sel;
        @(negedge clk) burst_clk = ~edge_sel;
        @(negedge clk);
    endtask

    task automatic start(input logic [20:0] a, input logic [1:0] m, input logic [2:0] l);
        @(negedge clk);
        ce_n = 1'b0; avd_n = 1'b0; addr_in = a; mode_in = m; lat_cfg = l;
        act_edge();
        avd_n = 1'b1; addr_in = '0;
        chk("R1 addr", addr_out, a);
        chk("R1 busy", {20'd0, busy}, 21'd1);
        chk("R1 rdy", {20'd0, rdy}, 21'd0);
    endtask

    task automatic wait_rdy(input logic [20:0] a, input int eff);
        for (int i = 1; i < eff; i++) begin
            act_edge();
            chk("R2 rdy low", {20'd0, rdy}, 21'd0);
        end
        act_edge();
        chk("R2 rdy high", {20'd0, rdy}, 21'd1);
        chk("R2 addr held", addr_out, a);
    endtask

    task automatic stop();
        @(negedge clk) ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 addr", addr_out, 21'd0);
        chk("R7 rdy", {20'd0, rdy}, 21'd0);
        chk("R7 busy", {20'd0, busy}, 21'd0);
    endtask

    task automatic t_wrap8();
        start(21'h000005, 2'b01, 3'd3);
        wait_rdy(21'h000005, 3);
        act_edge(); chk("R4 w8 6", addr_out, 21'h000006);
        act_edge(); chk("R4 w8 7", addr_out, 21'h000007);
        act_edge(); chk("R4 w8 wrap", addr_out, 21'h000000);
        act_edge(); chk("R4 w8 1", addr_out, 21'h000001);
        stop();
    endtask

    task automatic t_wrap16();
        start(21'h0ABC1E, 2'b10, 3'd0);
        wait_rdy(21'h0ABC1E, 2);
        act_edge(); chk("R4 w16 1f", addr_out, 21'h0ABC1F);
        act_edge(); chk("R4 w16 wrap", addr_out, 21'h0ABC10);
        stop();
    endtask

    task automatic t_wrap32();
        start(21'h12343D, 2'b11, 3'd7);
        wait_rdy(21'h12343D, 7);
        act_edge(); chk("R4 w32 3e", addr_out, 21'h12343E);
        act_edge(); chk("R4 w32 3f", addr_out, 21'h12343F);
        act_edge(); chk("R4 w32 wrap", addr_out, 21'h123420);
        stop();
    endtask

    task automatic t_cont();
        start(21'h1FFFFE, 2'b00, 3'd1);
        wait_rdy(21'h1FFFFE, 2);
        act_edge(); chk("R3 top", addr_out, 21'h1FFFFF);
        act_edge(); chk("R3 rollover", addr_out, 21'h000000);
        act_edge(); chk("R3 1", addr_out, 21'h000001);
        act_edge(); chk("R3 no wrap at 8", addr_out, 21'h000002);
        stop();
    endtask

    task automatic t_falling();
        @(negedge clk) edge_sel = 1'b1;
        start(21'h000100, 2'b00, 3'd2);
        wait_rdy(21'h000100, 2);
        // rising transition must be ignored
        @(negedge clk) burst_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 opposite ignored", addr_out, 21'h000100);
        act_edge(); chk("R5 falling steps", addr_out, 21'h000101);
        stop();
        @(negedge clk) edge_sel = 1'b0;
    endtask

    task automatic t_abort();
        start(21'h000040, 2'b00, 3'd2);
        wait_rdy(21'h000040, 2);
        act_edge();
        @(negedge clk) ce_n = 1'b1;
        @(negedge clk);
        chk("R6 rdy", {20'd0, rdy}, 21'd0);
        chk("R6 busy", {20'd0, busy}, 21'd0);
        chk("R6 addr held", addr_out, 21'h000041);
        act_edge();
        chk("R9 no step idle", addr_out, 21'h000041);
    endtask

    task automatic t_restart();
        start(21'h000200, 2'b00, 3'd2);
        wait_rdy(21'h000200, 2);
        act_edge();
        start(21'h000333, 2'b01, 3'd2);
        wait_rdy(21'h000333, 2);
        act_edge(); chk("R8 new burst", addr_out, 21'h000334);
        stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wrap8();
        t_wrap16();
        t_wrap32();
        t_cont();
        t_falling();
        t_abort();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_errs++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule